// File: doc/BRIEF.md
# Paged receive ring writer

This block stores incoming frames into a circular receive buffer carved into 256-byte pages. A frame arrives as a byte stream marked with first-byte and last-byte flags. The block writes its payload four bytes into the current page, pads short frames with zero bytes, and then goes back to the first four bytes of that page to write a status header. The header carries a good-frame status code, the page where the next frame will begin, and the stored length. It then moves its current-page pointer past the frame and raises a one-cycle receive interrupt.

The host owns three page numbers: the ring's first page, the page just past its last page, and a boundary page that marks where unread data begins. The block compares the space between its current page and the boundary with the largest possible frame, and reports a full flag. A frame that begins while the ring is full, or while the host holds the block halted, is discarded whole. A frame cut short by an abort strobe, or one that grows past the maximum frame size, leaves the current page where it was, so whatever it wrote is overwritten by the next frame.

The FSM states are IDLE (wait for a first byte; on accept write it and go to STORE, PAD or HDR; on refusal go to DISCARD), STORE (payload bytes; EOF goes to PAD or HDR; abort goes to IDLE; overlength goes to DISCARD or IDLE), PAD (zero fill up to the minimum size, then HDR), HDR (four header writes, then COMMIT), COMMIT (pointer update and interrupt, then IDLE) and DISCARD (swallow bytes until the last byte or an abort, then IDLE).

Top module: `rxring_writer`

## Requirements
- R1: While `halt` is high, an idle block loads `cur_page` from `pg_start`. A frame whose first byte arrives while halted causes no memory write, no interrupt and no change to `cur_page`.
- R2: `buf_full` is high exactly when the free space is below 1518 bytes. Free space is 256*(bound-cur) when cur < bound, and otherwise 256*((stop-start)-(cur-bound)).
- R3: A frame whose first byte arrives while `buf_full` is high is discarded: no write, no interrupt, and `cur_page` unchanged.
- R4: Payload byte i of an accepted frame goes to byte address cur*256+4+i. An address that reaches stop*256 continues at start*256.
- R5: A frame shorter than 60 bytes is followed by zero bytes at the next addresses, up to a stored size of 60.
- R6: The header occupies byte addresses cur*256+0..3. Byte 0 holds status 0x01, byte 1 the next page, byte 2 the low byte of (size+4) and byte 3 its high byte. Size is the stored size, after padding.
- R7: The next page is cur + floor((size+4+4+255)/256). If that result is at or beyond stop, (stop-start) is subtracted.
- R8: After the header, `cur_page` takes the next page in the same cycle that `rx_irq` is high for exactly one cycle, and `rx_status` reads 0x01.
- R9: An `rx_abort` during a frame drops it: no interrupt, and `cur_page` unchanged.
- R10: A frame with more than 1514 bytes is dropped with no interrupt and `cur_page` unchanged.
- R11: Every memory write falls within byte addresses start*256 to stop*256-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| halt | input | 1 | Host stop control; refuses frames and reloads the current page |
| pg_start | input | 8 | First page of the ring |
| pg_stop | input | 8 | Page just past the end of the ring |
| pg_bound | input | 8 | Host boundary page (oldest unread) |
| rx_valid | input | 1 | Byte valid on rx_data |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_abort | input | 1 | Drop the frame in progress |
| rx_data | input | 8 | Frame byte |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 16 | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write data |
| cur_page | output | 8 | Current page pointer |
| buf_full | output | 1 | Free space below one maximum frame |
| rx_irq | output | 1 | One-cycle pulse per stored frame |
| rx_status | output | 8 | Status of the last stored frame |

## Verification
A wrong write pointer shows up in the buffer memory image within one byte time. Either a payload byte lands at the wrong address or a write leaves the ring, so the bench compares every stored byte, including those that wrap past the stop page. A wrong page pointer or length count surfaces in the header and in `cur_page` a handful of cycles after the last byte, once the four header writes and the commit cycle have passed. Because `buf_full` is derived directly from the page registers, a wrong free-space calculation is visible at the port on the cycle the boundary changes, and the bench sweeps the boundary across every page of the ring to catch it.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    typedef enum logic [2:0] {
        RW_IDLE,
        RW_STORE,
        RW_PAD,
        RW_HDR,
        RW_COMMIT,
        RW_DISCARD
    } rw_state_e;

    localparam logic [7:0] RX_GOOD = 8'h01;
    localparam int HDR_BYTES = 4;
    localparam int CRC_ROOM  = 4;

endpackage

// File: rtl/rxring_space.sv
module rxring_space #(
    parameter int PG_W   = 8,
    parameter int MARGIN = 1518
) (
    input  logic [PG_W-1:0] cur,
    input  logic [PG_W-1:0] bound,
    input  logic [PG_W-1:0] start,
    input  logic [PG_W-1:0] stop,
    output logic            full
);
    localparam int SW = PG_W + 12;
    localparam logic signed [SW-1:0] LIMIT = SW'(MARGIN);

    logic signed [SW-1:0] c, b, s, e;
    logic signed [SW-1:0] avail_pg, avail_bytes;

    always_comb begin
        c = SW'(cur);
        b = SW'(bound);
        s = SW'(start);
        e = SW'(stop);
        if (c < b)
            avail_pg = b - c;
        else
            avail_pg = (e - s) - (c - b);
        avail_bytes = avail_pg <<< 8;
        full = (avail_bytes < LIMIT);
    end
endmodule

// File: rtl/rxring_next.sv
module rxring_next #(
    parameter int PG_W  = 8,
    parameter int CNT_W = 11
) (
    input  logic [PG_W-1:0]  cur,
    input  logic [PG_W-1:0]  start,
    input  logic [PG_W-1:0]  stop,
    input  logic [CNT_W-1:0] size,
    output logic [PG_W-1:0]  next_pg,
    output logic [7:0]       len_lo,
    output logic [7:0]       len_hi
);
    import rxring_pkg::*;

    localparam int SW = PG_W + CNT_W + 1;

    logic [SW-1:0] span, pages, raw, ring, wrapped;
    logic [15:0]   total;

    always_comb begin
        span    = SW'(size) + SW'(HDR_BYTES + CRC_ROOM + 255);
        pages   = span >> 8;
        raw     = SW'(cur) + pages;
        ring    = SW'(stop) - SW'(start);
        wrapped = (raw >= SW'(stop)) ? raw - ring : raw;
        next_pg = PG_W'(wrapped);
        total   = 16'(size) + 16'(HDR_BYTES);
        len_lo  = total[7:0];
        len_hi  = total[15:8];
    end
endmodule

// File: rtl/rxring_step.sv
module rxring_step #(
    parameter int PG_W = 8
) (
    input  logic [PG_W+7:0] ptr,
    input  logic [PG_W-1:0] start,
    input  logic [PG_W-1:0] stop,
    output logic [PG_W+7:0] nxt
);
    logic [PG_W+7:0] inc;

    always_comb begin
        inc = ptr + 1'b1;
        nxt = (inc == {stop, 8'h00}) ? {start, 8'h00} : inc;
    end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
    parameter int PG_W      = 8,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [PG_W-1:0]   pg_start,
    input  logic [PG_W-1:0]   pg_stop,
    input  logic [PG_W-1:0]   pg_bound,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_abort,
    input  logic [7:0]        rx_data,
    output logic              mem_we,
    output logic [PG_W+7:0]   mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [PG_W-1:0]   cur_page,
    output logic              buf_full,
    output logic              rx_irq,
    output logic [7:0]        rx_status
);
    import rxring_pkg::*;

    localparam int ADDR_W = PG_W + 8;
    localparam int MARGIN = MAX_FRAME + CRC_ROOM;
    localparam int CNT_W  = $clog2(MAX_FRAME + HDR_BYTES + CRC_ROOM + 256);
    localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_FRAME);
    localparam logic [CNT_W-1:0] MINC = CNT_W'(MIN_FRAME);

    rw_state_e          state, state_nx;
    logic [ADDR_W-1:0]  wr_ptr, step_nx, base;
    logic [CNT_W-1:0]   byte_cnt, cnt_inc;
    logic [1:0]         hdr_idx;
    logic [PG_W-1:0]    cur_q, next_pg;
    logic [7:0]         status_q, len_lo, len_hi;
    logic               irq_q, accept;

    assign base    = {cur_q, 8'h00};
    assign cnt_inc = byte_cnt + 1'b1;
    assign accept  = (state == RW_IDLE) && rx_valid && rx_sof && !halt && !buf_full;

    rxring_space #(.PG_W(PG_W), .MARGIN(MARGIN)) u_space (
        .cur(cur_q), .bound(pg_bound), .start(pg_start), .stop(pg_stop),
        .full(buf_full)
    );

    rxring_next #(.PG_W(PG_W), .CNT_W(CNT_W)) u_next (
        .cur(cur_q), .start(pg_start), .stop(pg_stop), .size(byte_cnt),
        .next_pg(next_pg), .len_lo(len_lo), .len_hi(len_hi)
    );

    rxring_step #(.PG_W(PG_W)) u_step (
        .ptr(mem_addr), .start(pg_start), .stop(pg_stop), .nxt(step_nx)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RW_IDLE: begin
                if (rx_valid && rx_sof) begin
                    if (halt || buf_full)
                        state_nx = rx_eof ? RW_IDLE : RW_DISCARD;
                    else if (rx_eof)
                        state_nx = (MIN_FRAME > 1) ? RW_PAD : RW_HDR;
                    else
                        state_nx = RW_STORE;
                end
            end
            RW_STORE: begin
                if (rx_abort)
                    state_nx = RW_IDLE;
                else if (rx_valid) begin
                    if (byte_cnt == MAXC)
                        state_nx = rx_eof ? RW_IDLE : RW_DISCARD;
                    else if (rx_eof)
                        state_nx = (cnt_inc < MINC) ? RW_PAD : RW_HDR;
                end
            end
            RW_PAD: begin
                if (cnt_inc >= MINC)
                    state_nx = RW_HDR;
            end
            RW_HDR: begin
                if (hdr_idx == 2'd3)
                    state_nx = RW_COMMIT;
            end
            RW_COMMIT: state_nx = RW_IDLE;
            RW_DISCARD: begin
                if (rx_abort || (rx_valid && rx_eof))
                    state_nx = RW_IDLE;
            end
            default: state_nx = RW_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RW_IDLE;
        else
            state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            byte_cnt <= '0;
            hdr_idx  <= '0;
            cur_q    <= '0;
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= (state == RW_COMMIT);
            unique case (state)
                RW_IDLE: begin
                    if (halt)
                        cur_q <= pg_start;
                    if (accept) begin
                        wr_ptr   <= step_nx;
                        byte_cnt <= CNT_W'(1);
                        hdr_idx  <= '0;
                    end
                end
                RW_STORE, RW_PAD: begin
                    if (mem_we) begin
                        wr_ptr   <= step_nx;
                        byte_cnt <= cnt_inc;
                    end
                end
                RW_HDR: hdr_idx <= hdr_idx + 1'b1;
                RW_COMMIT: begin
                    cur_q    <= next_pg;
                    status_q <= RX_GOOD;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = wr_ptr;
        mem_wdata = rx_data;
        unique case (state)
            RW_IDLE: begin
                mem_we   = accept;
                mem_addr = base + ADDR_W'(HDR_BYTES);
            end
            RW_STORE: mem_we = rx_valid && !rx_abort && (byte_cnt != MAXC);
            RW_PAD: begin
                mem_we    = 1'b1;
                mem_wdata = 8'h00;
            end
            RW_HDR: begin
                mem_we   = 1'b1;
                mem_addr = base | ADDR_W'(hdr_idx);
                unique case (hdr_idx)
                    2'd0: mem_wdata = RX_GOOD;
                    2'd1: mem_wdata = 8'(next_pg);
                    2'd2: mem_wdata = len_lo;
                    default: mem_wdata = len_hi;
                endcase
            end
            default: ;
        endcase
    end

    assign cur_page  = cur_q;
    assign rx_irq    = irq_q;
    assign rx_status = status_q;

    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    a_r8_irq_status: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_status == RX_GOOD));

    a_r8_cur_moves_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_page) && !$past(halt)) |-> rx_irq);

    a_r11_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr >= {pg_start, 8'h00}) && (mem_addr < {pg_stop, 8'h00})));

    a_r3_full_refused: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == RW_IDLE) && rx_valid && rx_sof && buf_full) |-> !mem_we);

    a_r1_halt_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && (state == RW_IDLE)) |=> !rx_irq);

endmodule

// File: tb/rxring_writer_bench.sv
`timescale 1ns/1ps
module rxring_writer_bench;

    localparam int START = 8'h40;
    localparam int STOP  = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b1;
    logic [7:0]  pg_start = 8'(START);
    logic [7:0]  pg_stop  = 8'(STOP);
    logic [7:0]  pg_bound = 8'(START);
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_abort = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_page;
    logic        buf_full, rx_irq;
    logic [7:0]  rx_status;

    int checks = 0, failures = 0;
    int wr_cnt = 0, oor_cnt = 0, irq_cnt = 0;
    bit done = 0;
    logic [7:0] bmem [0:65535];

    always #4 clk = ~clk;

    rxring_writer u_rxring_writer (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .pg_start(pg_start), .pg_stop(pg_stop), .pg_bound(pg_bound),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_abort(rx_abort), .rx_data(rx_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_page(cur_page), .buf_full(buf_full), .rx_irq(rx_irq),
        .rx_status(rx_status)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                bmem[mem_addr] <= mem_wdata;
                wr_cnt++;
                if (int'(mem_addr) < START * 256 || int'(mem_addr) >= STOP * 256)
                    oor_cnt++;
            end
            if (rx_irq) irq_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 31 + i * 7 + 1);
    endfunction

    function automatic int model_next(input int c, input int sz);
        int p;
        p = c + (sz + 4 + 4 + 255) / 256;
        if (p >= STOP) p -= (STOP - START);
        return p;
    endfunction

    function automatic bit model_full(input int c, input int b);
        int av;
        if (c < b) av = (b - c) * 256;
        else av = (STOP - START) * 256 - (c - b) * 256;
        return av < 1518;
    endfunction

    task automatic send_frame(input int n, input int seed, input int abort_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == abort_at) begin
                rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_abort = 1'b1;
                @(negedge clk);
                rx_abort = 1'b0;
                break;
            end
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == n - 1);
            rx_data  = pat(seed, i);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    task automatic good_frame(input int n, input int seed);
        int old, sz, a, mism, exp_next, irq0;
        logic [7:0] e;
        @(negedge clk);
        pg_bound = cur_page;
        @(negedge clk);
        old  = cur_page;
        irq0 = irq_cnt;
        sz   = (n < 60) ? 60 : n;
        exp_next = model_next(old, sz);
        send_frame(n, seed, -1);
        a = old * 256 + 4;
        mism = 0;
        for (int i = 0; i < sz; i++) begin
            e = (i < n) ? pat(seed, i) : 8'h00;
            if (bmem[a] !== e) mism++;
            a++;
            if (a == STOP * 256) a = START * 256;
        end
        check((n < 60) ? "R5 padded payload mismatches" : "R4 payload mismatches", mism, 0);
        check("R6 header status", int'(bmem[old * 256 + 0]), 1);
        check("R6 header next page", int'(bmem[old * 256 + 1]), exp_next);
        check("R6 header length low", int'(bmem[old * 256 + 2]), (sz + 4) % 256);
        check("R6 header length high", int'(bmem[old * 256 + 3]), (sz + 4) / 256);
        check("R7 cur_page after frame", int'(cur_page), exp_next);
        check("R8 one irq per frame", irq_cnt - irq0, 1);
        check("R8 rx_status", int'(rx_status), 1);
    endtask

    task automatic dropped(input string req, input int n, input int abort_at);
        int old, irq0;
        old  = cur_page;
        irq0 = irq_cnt;
        send_frame(n, 9, abort_at);
        check({req, " cur_page unchanged"}, int'(cur_page), old);
        check({req, " no irq"}, irq_cnt - irq0, 0);
    endtask

    initial begin
        for (int i = 0; i < 65536; i++) bmem[i] = 8'hEE;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: halted load, reset state
        check("R1 cur_page loads start while halted", int'(cur_page), START);
        check("R8 irq low after reset", int'(rx_irq), 0);
        check("R8 status after reset", int'(rx_status), 0);
        check("R11 no write after reset", int'(mem_we), 0);
        halt = 1'b0;
        repeat (2) @(negedge clk);

        // R4 R5 R6 R7 R8: frame size sweep, several wraps
        begin
            int sizes [14] = '{1, 59, 60, 61, 248, 249, 250, 500, 1000, 1514, 64, 300, 757, 2};
            for (int k = 0; k < 14; k++) good_frame(sizes[k], k + 3);
        end

        // R2: boundary sweep over every ring page
        for (int b = START; b < STOP; b++) begin
            @(negedge clk);
            pg_bound = 8'(b);
            @(negedge clk);
            check("R2 buf_full vs free-space formula", int'(buf_full), int'(model_full(cur_page, b)));
        end

        // R3: fill until full, then a frame is refused
        @(negedge clk);
        pg_bound = cur_page;
        for (int k = 0; k < 3; k++) begin
            int old, w0;
            old = cur_page;
            w0  = wr_cnt;
            send_frame(60, 20 + k, -1);
            check("R7 cur_page after fill frame", int'(cur_page), model_next(old, 60));
            check("R4 fill frame write count", wr_cnt - w0, 64);
        end
        check("R2 buf_full after three pages", int'(buf_full), 1);
        begin
            int w0;
            w0 = wr_cnt;
            dropped("R3", 60, -1);
            check("R3 no writes while full", wr_cnt - w0, 0);
        end

        // R1: halted frame dropped
        @(negedge clk);
        halt = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 halt reloads cur_page", int'(cur_page), START);
        begin
            int w0;
            w0 = wr_cnt;
            dropped("R1", 70, -1);
            check("R1 no writes while halted", wr_cnt - w0, 0);
        end
        halt = 1'b0;
        @(negedge clk);
        pg_bound = cur_page;

        // R9: abort mid-frame, then recovery
        dropped("R9", 100, 50);
        good_frame(90, 40);

        // R10: overlong frame
        @(negedge clk);
        pg_bound = cur_page;
        dropped("R10", 1515, -1);
        good_frame(61, 41);

        check("R11 writes outside ring", oor_cnt, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule